// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides an incoming feedback clock by a programmable ratio of M×N + A and marks the end of each division period with a single-clock comparison pulse. It models a dual-modulus prescaler and the two counters that steer it. M is the base modulus, chosen from two values by a select bit. N is an 11-bit main count. A is a 7-bit swallow count. For the first A prescaler sub-cycles of every period the prescaler divides by M+1. For the remaining N−A sub-cycles it divides by M. The comparison pulse feeds a phase comparator that runs against a reference divider outside this block.

Software writes a new N, A and modulus select through a single write strobe. The block checks the triple and holds it in a pending stage. It loads the triple into the counters only when the main count reaches its terminal value, so a period that has started always completes with the ratio it began with. A triple that breaks the rules (N below 5, or A not below N) is refused and flagged. Driving the run enable low freezes every counter where it stands. Raising it again resumes the period from that point.

A small phase machine drives the counting. It has three states. In HALT nothing counts. In SWALLOW the swallow count is nonzero and the prescaler spans M+1. In MAIN the swallow count is zero and the prescaler spans M. The transitions are:
- HALT→SWALLOW and HALT→MAIN when the enable is seen high, chosen by whether the swallow count is nonzero.
- SWALLOW→MAIN when the last swallow sub-cycle ends.
- MAIN→SWALLOW at a reload whose A is nonzero.
- SWALLOW→SWALLOW at a reload whose A is nonzero.
- MAIN→MAIN at a reload whose A is zero.
- Any state→HALT when the enable is seen low.

Top module: `pulse_swallow_div`

## Requirements
- R1: With run_en held high, successive rising cmp_pulse outputs are exactly M×N + A clocks apart. M is 16 when the active select is 1 and 32 when it is 0 (default parameters).
- R2: Within each period the prescaler first runs A sub-cycles of M+1 clocks, then N−A sub-cycles of M clocks. The swallow count never reaches or exceeds the remaining main count.
- R3: cmp_pulse is high for exactly one clock per period and is never high on two consecutive clocks.
- R4: A triple written with cfg_wr=1 does not disturb the period in progress. That period keeps its old length, and the new ratio governs the period that starts at the next terminal count.
- R5: A write sampled on the same clock edge as a terminal count is not used by that reload. The period that follows keeps the old ratio, and the written ratio takes over one period later.
- R6: Changes on ratio_sel, div_main or div_swallow while cfg_wr=0 have no effect on the period length.
- R7: A write with div_main below 5, or with div_swallow not below div_main, is refused. The previous legal ratio stays in force and cfg_err reads 1 from the clock after the write. A legal write clears cfg_err to 0 on the clock after it.
- R8: While run_en is low no cmp_pulse appears and all counters hold. A period that contains L disabled clocks is exactly L clocks longer than normal.
- R9: After reset with run_en low, no pulse appears and cfg_err is 0. The ratio in force is N=8, A=3, select=1, so the first full period after enabling is 131 clocks.
- R10: The modulus select is staged with N and A and changes the prescaler span only at a reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Feedback clock being divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | High lets the counters run; low freezes them |
| ratio_sel | input | 1 | Modulus select for the written triple: 1 picks the small base, 0 the large |
| div_main | input | N_W | Main count N for the written triple |
| div_swallow | input | A_W | Swallow count A for the written triple |
| cfg_wr | input | 1 | Write strobe that stages ratio_sel, div_main and div_swallow |
| cmp_pulse | output | 1 | One-clock pulse at the end of each division period |
| cfg_err | output | 1 | Set by a refused write, cleared by a legal write |

## Verification
Two events can fall on the same clock edge: a configuration write landing in the pending stage, and the terminal count that reloads the counters from that stage. The bench times a write so that its strobe is sampled exactly on a terminal edge, counting the period just observed. It then expects one more period at the old length before the new length appears. Freezing is provoked by dropping the enable in the middle of a period; the bench expects that period to stretch by the disabled clock count and no pulse to appear in the gap.

// File: rtl/psd_pkg.sv
package psd_pkg;

    // Counting phase of the divider.
    typedef enum logic [1:0] {
        PH_HALT    = 2'd0,
        PH_SWALLOW = 2'd1,
        PH_MAIN    = 2'd2
    } phase_e;

endpackage

// File: rtl/psd_cfg_stage.sv
module psd_cfg_stage #(
    parameter int N_W     = 11,
    parameter int A_W     = 7,
    parameter int N_MIN   = 5,
    parameter int DEF_N   = 8,
    parameter int DEF_A   = 3,
    parameter bit DEF_SEL = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr,
    input  logic           sel_in,
    input  logic [N_W-1:0] n_in,
    input  logic [A_W-1:0] a_in,
    output logic           pend_sel,
    output logic [N_W-1:0] pend_n,
    output logic [A_W-1:0] pend_a,
    output logic           err
);

    localparam logic [N_W-1:0] N_FLOOR = N_W'(N_MIN);

    logic [N_W-1:0] a_wide;
    logic           n_ok;
    logic           a_ok;
    logic           accept;

    always_comb begin
        a_wide = N_W'(a_in);
        n_ok   = (n_in >= N_FLOOR);
        a_ok   = (a_wide < n_in);
        accept = n_ok && a_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_sel <= DEF_SEL;
            pend_n   <= N_W'(DEF_N);
            pend_a   <= A_W'(DEF_A);
            err      <= 1'b0;
        end else if (wr) begin
            if (accept) begin
                pend_sel <= sel_in;
                pend_n   <= n_in;
                pend_a   <= a_in;
                err      <= 1'b0;
            end else begin
                err      <= 1'b1;
            end
        end
    end

    // R7: the staged triple is always legal
    assert_pending_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_n >= N_FLOOR) && (N_W'(pend_a) < pend_n));

    // R7: a short main count is refused and leaves the stage untouched
    assert_short_main_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (n_in < N_FLOOR)) |=> (err && $stable(pend_n) && $stable(pend_a)));

    // R7: a swallow count at or above the main count is refused
    assert_big_swallow_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (N_W'(a_in) >= n_in)) |=> (err && $stable(pend_sel)));

    // R6: without a write the stage holds
    assert_stage_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ($stable(pend_n) && $stable(pend_a) && $stable(pend_sel) && $stable(err)));

endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
    parameter int MOD_SMALL = 16,
    parameter int MOD_LARGE = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    input  logic use_small,
    input  logic add_one,
    output logic tick
);

    localparam int PW = $clog2(MOD_LARGE + 2);

    logic [PW-1:0] pcnt;
    logic [PW-1:0] span;
    logic [PW-1:0] last;

    always_comb begin
        span = use_small ? PW'(MOD_SMALL) : PW'(MOD_LARGE);
        if (add_one) begin
            span = span + PW'(1);
        end
        last = span - PW'(1);
        tick = advance && (pcnt == last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (advance) begin
            pcnt <= tick ? '0 : pcnt + PW'(1);
        end
    end

    // R2: while counting, the prescaler position stays inside its span
    assert_prescale_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> (pcnt <= last));

    // R2: each sub-cycle restarts from zero
    assert_prescale_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pcnt == '0));

    // R8: a frozen prescaler keeps its position
    assert_prescale_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(pcnt));

endmodule

// File: rtl/psd_swallow_ctrl.sv
module psd_swallow_ctrl
    import psd_pkg::*;
#(
    parameter int N_W     = 11,
    parameter int A_W     = 7,
    parameter int DEF_N   = 8,
    parameter int DEF_A   = 3,
    parameter bit DEF_SEL = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run_en,
    input  logic           tick,
    input  logic           pend_sel,
    input  logic [N_W-1:0] pend_n,
    input  logic [A_W-1:0] pend_a,
    output logic           advance,
    output logic           act_sel,
    output logic           swallow_on,
    output logic           cmp_pulse
);

    phase_e         state;
    phase_e         state_nxt;
    logic [N_W-1:0] ncnt;
    logic [N_W-1:0] ncnt_nxt;
    logic [A_W-1:0] acnt;
    logic [A_W-1:0] acnt_nxt;
    logic           sel_nxt;
    logic           terminal;

    always_comb begin
        advance    = (state != PH_HALT);
        swallow_on = (state == PH_SWALLOW);
        terminal   = tick && (ncnt == N_W'(1));
    end

    // Counter next values
    always_comb begin
        ncnt_nxt = ncnt;
        acnt_nxt = acnt;
        sel_nxt  = act_sel;
        if (terminal) begin
            ncnt_nxt = pend_n;
            acnt_nxt = pend_a;
            sel_nxt  = pend_sel;
        end else if (tick) begin
            ncnt_nxt = ncnt - N_W'(1);
            if (acnt != '0) begin
                acnt_nxt = acnt - A_W'(1);
            end
        end
    end

    // Phase transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            PH_HALT: begin
                if (run_en) begin
                    state_nxt = (acnt != '0) ? PH_SWALLOW : PH_MAIN;
                end
            end
            PH_SWALLOW, PH_MAIN: begin
                if (!run_en) begin
                    state_nxt = PH_HALT;
                end else begin
                    state_nxt = (acnt_nxt != '0) ? PH_SWALLOW : PH_MAIN;
                end
            end
            default: state_nxt = PH_HALT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_HALT;
        end else begin
            state <= state_nxt;
        end
    end

    // Counter registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ncnt    <= N_W'(DEF_N);
            acnt    <= A_W'(DEF_A);
            act_sel <= DEF_SEL;
        end else begin
            ncnt    <= ncnt_nxt;
            acnt    <= acnt_nxt;
            act_sel <= sel_nxt;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_pulse <= 1'b0;
        end else begin
            cmp_pulse <= terminal;
        end
    end

    // R3: the comparison pulse is one clock wide
    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_pulse |=> !cmp_pulse);

    // R8: a halted divider emits no pulse and holds its counts
    assert_halt_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_HALT) |=> (!cmp_pulse && $stable(ncnt) && $stable(acnt)));

    // R2: the wide-span phase tracks a nonzero swallow count
    assert_swallow_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PH_HALT) |-> ((state == PH_SWALLOW) == (acnt != '0)));

    // R2: the swallow count stays below the remaining main count
    assert_swallow_below_main_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (N_W'(acnt) < ncnt));

    // R10: the modulus select moves only at a reload
    assert_sel_at_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !terminal |=> $stable(act_sel));

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
    parameter int N_W       = 11,
    parameter int A_W       = 7,
    parameter int N_MIN     = 5,
    parameter int MOD_SMALL = 16,
    parameter int MOD_LARGE = 32,
    parameter int DEF_N     = 8,
    parameter int DEF_A     = 3,
    parameter bit DEF_SEL   = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run_en,
    input  logic           ratio_sel,
    input  logic [N_W-1:0] div_main,
    input  logic [A_W-1:0] div_swallow,
    input  logic           cfg_wr,
    output logic           cmp_pulse,
    output logic           cfg_err
);

    logic           pend_sel;
    logic [N_W-1:0] pend_n;
    logic [A_W-1:0] pend_a;
    logic           advance;
    logic           act_sel;
    logic           swallow_on;
    logic           tick;

    psd_cfg_stage #(
        .N_W(N_W), .A_W(A_W), .N_MIN(N_MIN),
        .DEF_N(DEF_N), .DEF_A(DEF_A), .DEF_SEL(DEF_SEL)
    ) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .sel_in  (ratio_sel),
        .n_in    (div_main),
        .a_in    (div_swallow),
        .pend_sel(pend_sel),
        .pend_n  (pend_n),
        .pend_a  (pend_a),
        .err     (cfg_err)
    );

    psd_prescaler #(
        .MOD_SMALL(MOD_SMALL), .MOD_LARGE(MOD_LARGE)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (advance),
        .use_small(act_sel),
        .add_one  (swallow_on),
        .tick     (tick)
    );

    psd_swallow_ctrl #(
        .N_W(N_W), .A_W(A_W),
        .DEF_N(DEF_N), .DEF_A(DEF_A), .DEF_SEL(DEF_SEL)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .tick      (tick),
        .pend_sel  (pend_sel),
        .pend_n    (pend_n),
        .pend_a    (pend_a),
        .advance   (advance),
        .act_sel   (act_sel),
        .swallow_on(swallow_on),
        .cmp_pulse (cmp_pulse)
    );

endmodule

// File: tb/tb_pulse_swallow_div.sv
`timescale 1ns/1ps
module tb_pulse_swallow_div;

    localparam int NV    = 9;
    localparam int LIMIT = 180000;
    // {select, N, A, expected period}
    localparam int VEC [NV][4] = '{
        '{1,    5,   0,    80},
        '{0,    5,   4,   164},
        '{1,   10,   9,   169},
        '{0,    6,   0,   192},
        '{1,   20,  19,   339},
        '{0,    7,   6,   230},
        '{0,    9,   1,   289},
        '{1, 2047, 127, 32879},
        '{1,    8,   3,   131}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        ratio_sel = 1'b1;
    logic [10:0] div_main = 11'd8;
    logic [6:0]  div_swallow = 7'd3;
    logic        cfg_wr = 1'b0;
    logic        cmp_pulse;
    logic        cfg_err;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int last_p = 0;
    int intv = 0;
    int npulse = 0;
    int dbl = 0;
    logic prev_p = 1'b0;

    always #5 clk = ~clk;

    pulse_swallow_div dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .ratio_sel(ratio_sel),
        .div_main(div_main), .div_swallow(div_swallow), .cfg_wr(cfg_wr),
        .cmp_pulse(cmp_pulse), .cfg_err(cfg_err)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (cmp_pulse) begin
            if (prev_p) dbl = dbl + 1;
            intv = cyc - last_p;
            last_p = cyc;
            npulse = npulse + 1;
        end
        prev_p = cmp_pulse;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse();
        int target;
        target = npulse + 1;
        while (npulse < target) @(posedge clk);
        #1;
    endtask

    task automatic write_cfg(input int sel, input int n, input int a);
        ratio_sel = sel[0];
        div_main = 11'(n);
        div_swallow = 7'(a);
        cfg_wr = 1'b1;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic run_all();
        int prev_exp;
        int np;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (300) @(posedge clk);
        #1;
        chk("R9 no pulse while disabled", npulse, 0);
        chk("R9 cfg_err after reset", int'(cfg_err), 0);
        run_en = 1'b1;
        wait_pulse();
        wait_pulse();
        chk("R9 default period", intv, 131);

        // R1 R2 R4 R10: table of ratios
        prev_exp = 131;
        for (int i = 0; i < NV; i++) begin
            wait_pulse();
            write_cfg(VEC[i][0], VEC[i][1], VEC[i][2]);
            chk("R7 legal write leaves cfg_err low", int'(cfg_err), 0);
            wait_pulse();
            chk("R4 period in progress keeps old ratio", intv, prev_exp);
            wait_pulse();
            chk("R1 period equals M*N+A", intv, VEC[i][3]);
            prev_exp = VEC[i][3];
        end

        // R6 R10: inputs without a write are ignored
        ratio_sel = 1'b0; div_main = 11'd100; div_swallow = 7'd50;
        wait_pulse();
        wait_pulse();
        chk("R6 unwritten inputs ignored", intv, 131);

        // R7: short main count refused
        wait_pulse();
        write_cfg(0, 4, 0);
        chk("R7 cfg_err after short N", int'(cfg_err), 1);
        wait_pulse();
        wait_pulse();
        chk("R7 old ratio kept after short N", intv, 131);

        // R7: swallow count not below main count refused
        wait_pulse();
        write_cfg(1, 6, 6);
        chk("R7 cfg_err after A>=N", int'(cfg_err), 1);
        wait_pulse();
        wait_pulse();
        chk("R7 old ratio kept after A>=N", intv, 131);

        // R7: legal write clears the flag
        wait_pulse();
        write_cfg(1, 5, 0);
        chk("R7 cfg_err cleared", int'(cfg_err), 0);
        wait_pulse();
        wait_pulse();
        chk("R1 period after recovery", intv, 80);

        // R5: write sampled on the terminal edge
        wait_pulse();
        repeat (80 - 2) @(posedge clk);
        #1;
        write_cfg(1, 6, 2);
        wait_pulse();
        wait_pulse();
        chk("R5 coincident write not used at that reload", intv, 80);
        wait_pulse();
        chk("R5 coincident write used one period later", intv, 98);

        // R8: freeze in mid period
        wait_pulse();
        repeat (20) @(posedge clk);
        #1 run_en = 1'b0;
        np = npulse;
        repeat (50) @(posedge clk);
        #1;
        chk("R8 no pulse while frozen", npulse, np);
        run_en = 1'b1;
        wait_pulse();
        chk("R8 period stretched by frozen clocks", intv, 148);
        wait_pulse();
        chk("R8 period after resume", intv, 98);

        chk("R3 pulse never two clocks wide", dbl, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                while (cyc < LIMIT) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, LIMIT);
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule